// File: doc/BRIEF.md
# Dual-Port Access Decoder with Crossing Mailboxes

This block sits between two independent clock domains that share a two-direction 36-bit buffer. Each side has a chip select, a write/read select, an enable and a mailbox select. On each rising edge of its own clock, a side can do one of four things: push its outbound queue, load its outbound mailbox register, pop its inbound queue, or take its inbound mailbox word. The queue storage is outside the block. The block decodes the control lines into the queue write and read strobes, gated by the queue's ready signals.

For each side the block also produces an output-enable for the external tri-state bus. It selects, without any clock edge, whether the bus carries the inbound queue's output register or the inbound mailbox register. Two mailbox registers pass words in opposite directions. Each has an active-low full flag that lives in the reading side's clock domain. A write in the other domain sets the flag, and a mailbox read in the reading domain clears it.

The two sides use opposite polarities of the write/read select. On side A a high level selects a write. On side B a high level selects a read.

Top module: `bidir_mbox_ctrl`

## Requirements
- R1: Side A output-enable `a_oe_o` is 1 only when `a_cs_ni`=0 and `a_wr_rd_i`=0 (read). It is 0 whenever `a_cs_ni`=1 or `a_wr_rd_i`=1.
- R2: Side B output-enable `b_oe_o` is 1 only when `b_cs_ni`=0 and `b_wr_rd_i`=1 (read). It is 0whenever `b_cs_ni`=1 or `b_wr_rd_i`=0.
- R3: The queue write strobe of a side is 1 only when all of these hold: chip select is 0, the write direction is selected, enable is 1, mailbox select is 0 and the queue's input-ready is 1.
- R4: The queue read strobe of a side is 1 only when all of these hold: chip select is 0, the read direction is selected, enable is 1, mailbox select is 0 and the queue's output-ready is 1.
- R5: A rising edge in the write direction with chip select 0, enable 1 and mailbox select 1 loads the side's data input into its outbound mailbox. During that access both queue strobes of the side stay 0.
- R6: With the read direction selected, the data output shows the inbound mailbox register when mailbox select is 1 and the queue output input when it is 0. This follows the inputs with no clock edge.
- R7: A rising edge in the read direction with chip select 0, enable 1 and mailbox select 1 takes the inbound mailbox word and returns its full flag to 1 (not full).
- R8: While enable is 0, no queue strobe is raised and no mailbox is loaded or emptied, whatever the other control inputs are.
- R9: A mailbox load drives the reading side's full flag to 0 within SYNC_STAGES+2 reading-clock edges.
- R10: A mailbox load while the full flag is still 0 replaces the stored word with the new one, and the flag stays 0.
- R11: Both sides can perform accesses in the same period without affecting each other.
- R12: When a new-load event reaches the reading domain on the same edge as a mailbox read, the flag goes to 0 (set wins). It returns to 1 only on a later read.
- R13: After reset both full flags are 1 and both mailbox registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Side A clock |
| clk_b_i | input | 1 | Side B clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| a_cs_ni | input | 1 | Side A chip select, active low |
| a_wr_rd_i | input | 1 | Side A direction: 1 write, 0 read |
| a_en_i | input | 1 | Side A access enable |
| a_mbx_i | input | 1 | Side A mailbox select |
| a_data_i | input | DW | Side A write data |
| a_data_o | output | DW | Side A read data (mux output) |
| a_oe_o | output | 1 | Side A bus output-enable |
| a_fifo_wr_o | output | 1 | Write strobe to the A-to-B queue |
| a_in_rdy_i | input | 1 | A-to-B queue can accept a word |
| a_fifo_rd_o | output | 1 | Read strobe to the B-to-A queue |
| a_out_rdy_i | input | 1 | B-to-A queue output register valid |
| a_fifo_q_i | input | DW | B-to-A queue output register |
| a_mbx_full_no | output | 1 | B-to-A mailbox full, active low, clk_a domain |
| b_cs_ni | input | 1 | Side B chip select, active low |
| b_wr_rd_i | input | 1 | Side B direction: 0 write, 1 read |
| b_en_i | input | 1 | Side B access enable |
| b_mbx_i | input | 1 | Side B mailbox select |
| b_data_i | input | DW | Side B write data |
| b_data_o | output | DW | Side B read data (mux output) |
| b_oe_o | output | 1 | Side B bus output-enable |
| b_fifo_wr_o | output | 1 | Write strobe to the B-to-A queue |
| b_in_rdy_i | input | 1 | B-to-A queue can accept a word |
| b_fifo_rd_o | output | 1 | Read strobe to the A-to-B queue |
| b_out_rdy_i | input | 1 | A-to-B queue output register valid |
| b_fifo_q_i | input | DW | A-to-B queue output register |
| b_mbx_full_no | output | 1 | A-to-B mailbox full, active low, clk_b domain |

## Verification
Two functions can land on the same reading-clock edge: the synchronized new-load event that sets a mailbox's full flag, and a mailbox read that clears it. The bench provokes this by holding a mailbox read on side B over many consecutive edges while side A loads the mailbox. The collision then happens on whichever edge the event arrives. The result is judged by requiring that the flag is seen at 0 for at least one sampled period and is back at 1 afterwards. If the clear took priority, the flag would never drop.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_FIFO_WR = 3'd1,
    ACT_MBX_WR  = 3'd2,
    ACT_FIFO_RD = 3'd3,
    ACT_MBX_RD  = 3'd4
  } bmc_act_e;
endpackage

// File: rtl/bmc_sync.sv
`timescale 1ns/1ps
module bmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[0] <= 1'b0;
          else         pipe_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= pipe_q[i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bmc_port_dec.sv
`timescale 1ns/1ps
module bmc_port_dec import bmc_pkg::*; #(
  parameter bit WR_LVL = 1'b1  // level of wr_rd_i that selects a write
) (
  input  logic     cs_ni,
  input  logic     wr_rd_i,
  input  logic     en_i,
  input  logic     mbx_i,
  input  logic     in_rdy_i,
  input  logic     out_rdy_i,
  output bmc_act_e act_o,
  output logic     oe_o,
  output logic     mux_mbx_o
);
  logic sel, wr_dir;

  assign sel    = ~cs_ni;
  assign wr_dir = (wr_rd_i == WR_LVL);

  always_comb begin
    act_o = ACT_IDLE;
    if (sel && en_i) begin
      if (wr_dir) begin
        if (mbx_i)         act_o = ACT_MBX_WR;
        else if (in_rdy_i) act_o = ACT_FIFO_WR;
      end else begin
        if (mbx_i)          act_o = ACT_MBX_RD;
        else if (out_rdy_i) act_o = ACT_FIFO_RD;
      end
    end
  end

  assign oe_o      = sel & ~wr_dir;
  assign mux_mbx_o = ~wr_dir & mbx_i;
endmodule

// File: rtl/bmc_mailbox.sv
`timescale 1ns/1ps
module bmc_mailbox #(
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_no
);
  logic [DW-1:0] data_q;
  logic          wtgl_q;
  logic          wtgl_s;
  logic          wtgl_d;
  logic          load_evt;
  logic          full_q;

  // writer domain: storage and load toggle
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wtgl_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      wtgl_q <= ~wtgl_q;
    end
  end

  bmc_sync #(.STAGES(SYNC_STAGES)) i_tgl_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wtgl_q),
    .q_o   (wtgl_s)
  );

  // reader domain: edge detect, set beats clear
  assign load_evt = wtgl_s ^ wtgl_d;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wtgl_d <= 1'b0;
      full_q <= 1'b0;
    end else begin
      wtgl_d <= wtgl_s;
      if (load_evt)  full_q <= 1'b1;
      else if (rd_i) full_q <= 1'b0;
    end
  end

  assign rdata_o = data_q;
  assign full_no = ~full_q;
endmodule

// File: rtl/bidir_mbox_ctrl.sv
`timescale 1ns/1ps
module bidir_mbox_ctrl import bmc_pkg::*; #(
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_cs_ni,
  input  logic          a_wr_rd_i,
  input  logic          a_en_i,
  input  logic          a_mbx_i,
  input  logic [DW-1:0] a_data_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_oe_o,
  output logic          a_fifo_wr_o,
  input  logic          a_in_rdy_i,
  output logic          a_fifo_rd_o,
  input  logic          a_out_rdy_i,
  input  logic [DW-1:0] a_fifo_q_i,
  output logic          a_mbx_full_no,
  input  logic          b_cs_ni,
  input  logic          b_wr_rd_i,
  input  logic          b_en_i,
  input  logic          b_mbx_i,
  input  logic [DW-1:0] b_data_i,
  output logic [DW-1:0] b_data_o,
  output logic          b_oe_o,
  output logic          b_fifo_wr_o,
  input  logic          b_in_rdy_i,
  output logic          b_fifo_rd_o,
  input  logic          b_out_rdy_i,
  input  logic [DW-1:0] b_fifo_q_i,
  output logic          b_mbx_full_no
);
  bmc_act_e      a_act, b_act;
  logic          a_mux_mbx, b_mux_mbx;
  logic [DW-1:0] mbx_ab_q, mbx_ba_q;

  bmc_port_dec #(.WR_LVL(1'b1)) i_dec_a (
    .cs_ni    (a_cs_ni),
    .wr_rd_i  (a_wr_rd_i),
    .en_i     (a_en_i),
    .mbx_i    (a_mbx_i),
    .in_rdy_i (a_in_rdy_i),
    .out_rdy_i(a_out_rdy_i),
    .act_o    (a_act),
    .oe_o     (a_oe_o),
    .mux_mbx_o(a_mux_mbx)
  );

  bmc_port_dec #(.WR_LVL(1'b0)) i_dec_b (
    .cs_ni    (b_cs_ni),
    .wr_rd_i  (b_wr_rd_i),
    .en_i     (b_en_i),
    .mbx_i    (b_mbx_i),
    .in_rdy_i (b_in_rdy_i),
    .out_rdy_i(b_out_rdy_i),
    .act_o    (b_act),
    .oe_o     (b_oe_o),
    .mux_mbx_o(b_mux_mbx)
  );

  // A loads, B reads
  bmc_mailbox #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_mbx_ab (
    .wclk_i (clk_a_i),
    .rclk_i (clk_b_i),
    .rst_ni (rst_ni),
    .wr_i   (a_act == ACT_MBX_WR),
    .wdata_i(a_data_i),
    .rd_i   (b_act == ACT_MBX_RD),
    .rdata_o(mbx_ab_q),
    .full_no(b_mbx_full_no)
  );

  // B loads, A reads
  bmc_mailbox #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_mbx_ba (
    .wclk_i (clk_b_i),
    .rclk_i (clk_a_i),
    .rst_ni (rst_ni),
    .wr_i   (b_act == ACT_MBX_WR),
    .wdata_i(b_data_i),
    .rd_i   (a_act == ACT_MBX_RD),
    .rdata_o(mbx_ba_q),
    .full_no(a_mbx_full_no)
  );

  assign a_fifo_wr_o = (a_act == ACT_FIFO_WR);
  assign a_fifo_rd_o = (a_act == ACT_FIFO_RD);
  assign b_fifo_wr_o = (b_act == ACT_FIFO_WR);
  assign b_fifo_rd_o = (b_act == ACT_FIFO_RD);

  assign a_data_o = a_mux_mbx ? mbx_ba_q : a_fifo_q_i;
  assign b_data_o = b_mux_mbx ? mbx_ab_q : b_fifo_q_i;
endmodule

// File: rtl/bmc_chk.sv
`timescale 1ns/1ps
module bmc_chk #(
  parameter int DW = 36
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          a_cs_ni,
  input logic          a_wr_rd_i,
  input logic          a_en_i,
  input logic          a_mbx_i,
  input logic          a_oe_o,
  input logic          a_fifo_wr_o,
  input logic          a_fifo_rd_o,
  input logic          a_in_rdy_i,
  input logic          b_cs_ni,
  input logic          b_wr_rd_i,
  input logic          b_en_i,
  input logic          b_mbx_i,
  input logic [DW-1:0] b_data_o,
  input logic [DW-1:0] b_fifo_q_i,
  input logic          b_oe_o,
  input logic          b_fifo_wr_o,
  input logic          b_fifo_rd_o,
  input logic          b_out_rdy_i,
  input logic          b_mbx_full_no
);
  // R1
  a_oe_hiz_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_cs_ni || a_wr_rd_i) |-> !a_oe_o);

  // R2
  b_oe_hiz_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_cs_ni || !b_wr_rd_i) |-> !b_oe_o);

  // R3
  a_fifo_wr_qual_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_fifo_wr_o |-> (!a_cs_ni && a_wr_rd_i && a_en_i && !a_mbx_i && a_in_rdy_i));

  // R4
  b_fifo_rd_qual_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    b_fifo_rd_o |-> (!b_cs_ni && b_wr_rd_i && b_en_i && !b_mbx_i && b_out_rdy_i));

  // R5
  a_mbx_no_fifo_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_mbx_i && a_en_i) |-> (!a_fifo_wr_o && !a_fifo_rd_o));

  // R6
  b_mux_fifo_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_wr_rd_i && !b_mbx_i) |-> (b_data_o == b_fifo_q_i));

  // R7
  b_flag_clear_cause_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(b_mbx_full_no) |-> $past(!b_cs_ni && b_wr_rd_i && b_en_i && b_mbx_i));

  // R8
  a_en_low_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_en_i |-> (!a_fifo_wr_o && !a_fifo_rd_o));

  // R8
  b_en_low_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !b_en_i |-> (!b_fifo_wr_o && !b_fifo_rd_o));
endmodule

bind bidir_mbox_ctrl bmc_chk #(.DW(DW)) i_bmc_chk (
  .clk_a_i      (clk_a_i),
  .clk_b_i      (clk_b_i),
  .rst_ni       (rst_ni),
  .a_cs_ni      (a_cs_ni),
  .a_wr_rd_i    (a_wr_rd_i),
  .a_en_i       (a_en_i),
  .a_mbx_i      (a_mbx_i),
  .a_oe_o       (a_oe_o),
  .a_fifo_wr_o  (a_fifo_wr_o),
  .a_fifo_rd_o  (a_fifo_rd_o),
  .a_in_rdy_i   (a_in_rdy_i),
  .b_cs_ni      (b_cs_ni),
  .b_wr_rd_i    (b_wr_rd_i),
  .b_en_i       (b_en_i),
  .b_mbx_i      (b_mbx_i),
  .b_data_o     (b_data_o),
  .b_fifo_q_i   (b_fifo_q_i),
  .b_oe_o       (b_oe_o),
  .b_fifo_wr_o  (b_fifo_wr_o),
  .b_fifo_rd_o  (b_fifo_rd_o),
  .b_out_rdy_i  (b_out_rdy_i),
  .b_mbx_full_no(b_mbx_full_no)
);

// File: tb/test_bidir_mbox_ctrl.sv
`timescale 1ns/1ps
module test_bidir_mbox_ctrl;
  localparam int DW = 36;
  localparam logic [DW-1:0] A_Q = 36'hA_5A5A_0F0F;
  localparam logic [DW-1:0] B_Q = 36'h3_C3C3_F0F0;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_ni = 1'b0;
  logic a_cs_ni, a_wr_rd_i, a_en_i, a_mbx_i, a_in_rdy_i, a_out_rdy_i;
  logic b_cs_ni, b_wr_rd_i, b_en_i, b_mbx_i, b_in_rdy_i, b_out_rdy_i;
  logic [DW-1:0] a_data_i, b_data_i, a_data_o, b_data_o;
  logic a_oe_o, b_oe_o, a_fifo_wr_o, a_fifo_rd_o, b_fifo_wr_o, b_fifo_rd_o;
  logic a_mbx_full_no, b_mbx_full_no;

  int checks = 0, errors = 0;

  always #2 clk_a = ~clk_a;  // 250 MHz
  always #3 clk_b = ~clk_b;

  bidir_mbox_ctrl i_bidir_mbox_ctrl (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .a_cs_ni(a_cs_ni), .a_wr_rd_i(a_wr_rd_i), .a_en_i(a_en_i), .a_mbx_i(a_mbx_i),
    .a_data_i(a_data_i), .a_data_o(a_data_o), .a_oe_o(a_oe_o),
    .a_fifo_wr_o(a_fifo_wr_o), .a_in_rdy_i(a_in_rdy_i),
    .a_fifo_rd_o(a_fifo_rd_o), .a_out_rdy_i(a_out_rdy_i),
    .a_fifo_q_i(A_Q), .a_mbx_full_no(a_mbx_full_no),
    .b_cs_ni(b_cs_ni), .b_wr_rd_i(b_wr_rd_i), .b_en_i(b_en_i), .b_mbx_i(b_mbx_i),
    .b_data_i(b_data_i), .b_data_o(b_data_o), .b_oe_o(b_oe_o),
    .b_fifo_wr_o(b_fifo_wr_o), .b_in_rdy_i(b_in_rdy_i),
    .b_fifo_rd_o(b_fifo_rd_o), .b_out_rdy_i(b_out_rdy_i),
    .b_fifo_q_i(B_Q), .b_mbx_full_no(b_mbx_full_no)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_set(input logic cs, input logic wr, input logic en, input logic mbx);
    a_cs_ni = cs; a_wr_rd_i = wr; a_en_i = en; a_mbx_i = mbx;
  endtask

  task automatic b_set(input logic cs, input logic wr, input logic en, input logic mbx);
    b_cs_ni = cs; b_wr_rd_i = wr; b_en_i = en; b_mbx_i = mbx;
  endtask

  task automatic a_mbx_load(input logic [DW-1:0] d);
    @(negedge clk_a);
    a_set(1'b0, 1'b1, 1'b1, 1'b1); a_data_i = d;
    #1 chk("R5 strobes quiet", {34'd0, a_fifo_wr_o, a_fifo_rd_o}, '0);
    @(negedge clk_a);
    a_set(1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic b_mbx_load(input logic [DW-1:0] d);
    @(negedge clk_b);
    b_set(1'b0, 1'b0, 1'b1, 1'b1); b_data_i = d;
    @(negedge clk_b);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic b_mbx_take();
    @(negedge clk_b);
    b_set(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk_b);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic t_reset();
    chk("R13 b flag", {35'd0, b_mbx_full_no}, 36'd1);
    chk("R13 a flag", {35'd0, a_mbx_full_no}, 36'd1);
    b_set(1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R13 mailbox zero", b_data_o, '0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_oe();
    for (int i = 0; i < 4; i++) begin
      a_set(i[1], i[0], 1'b0, 1'b0);
      b_set(i[1], i[0], 1'b0, 1'b0);
      #1;
      chk("R1 a_oe", {35'd0, a_oe_o}, {35'd0, (i == 0)});
      chk("R2 b_oe", {35'd0, b_oe_o}, {35'd0, (i == 1)});
    end
    a_set(1'b1, 1'b1, 1'b0, 1'b0); b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fifo_strobes();
    a_set(1'b0, 1'b1, 1'b1, 1'b0); a_in_rdy_i = 1'b1;
    #1 chk("R3 a write", {35'd0, a_fifo_wr_o}, 36'd1);
    a_in_rdy_i = 1'b0;
    #1 chk("R3 a write not ready", {35'd0, a_fifo_wr_o}, 36'd0);
    a_set(1'b1, 1'b1, 1'b1, 1'b0); a_in_rdy_i = 1'b1;
    #1 chk("R3 a write deselected", {35'd0, a_fifo_wr_o}, 36'd0);
    a_set(1'b0, 1'b0, 1'b1, 1'b0); a_out_rdy_i = 1'b1;
    #1 chk("R4 a read", {34'd0, a_fifo_rd_o, a_fifo_wr_o}, 36'd2);
    chk("R6 a mux queue", a_data_o, A_Q);
    b_set(1'b0, 1'b1, 1'b1, 1'b0); b_out_rdy_i = 1'b1;
    #1 chk("R4 b read", {35'd0, b_fifo_rd_o}, 36'd1);
    b_out_rdy_i = 1'b0;
    #1 chk("R4 b read not ready", {35'd0, b_fifo_rd_o}, 36'd0);
    b_set(1'b0, 1'b0, 1'b1, 1'b0); b_in_rdy_i = 1'b1;
    #1 chk("R3 b write", {34'd0, b_fifo_wr_o, b_fifo_rd_o}, 36'd2);
    a_set(1'b1, 1'b1, 1'b0, 1'b0); b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mbx_ab();
    a_mbx_load(36'h1_2345_6789);
    wait_b(4);  // SYNC_STAGES+2
    chk("R9 flag low", {35'd0, b_mbx_full_no}, 36'd0);
    b_set(1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R6 mux mailbox", b_data_o, 36'h1_2345_6789);
    b_mbx_take();
    chk("R7 flag high after read", {35'd0, b_mbx_full_no}, 36'd1);
  endtask

  task automatic t_en_low();
    @(negedge clk_a);
    a_set(1'b0, 1'b1, 1'b0, 1'b1); a_data_i = 36'hF_FFFF_FFFF; a_in_rdy_i = 1'b1;
    repeat (3) @(negedge clk_a);
    a_set(1'b1, 1'b1, 1'b0, 1'b0);
    wait_b(6);
    chk("R8 no load flag", {35'd0, b_mbx_full_no}, 36'd1);
    b_set(1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R8 word unchanged", b_data_o, 36'h1_2345_6789);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
    // enable-low read must not clear a full flag
    a_mbx_load(36'h0_0000_00AA);
    wait_b(6);
    @(negedge clk_b); b_set(1'b0, 1'b1, 1'b0, 1'b1);
    wait_b(3);
    chk("R8 no clear flag", {35'd0, b_mbx_full_no}, 36'd0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
    b_mbx_take();
  endtask

  task automatic t_overwrite();
    a_mbx_load(36'h0_1111_1111);
    wait_b(6);
    a_mbx_load(36'h0_2222_2222);
    wait_b(6);
    chk("R10 still full", {35'd0, b_mbx_full_no}, 36'd0);
    b_set(1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R10 newest word", b_data_o, 36'h0_2222_2222);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
    b_mbx_take();
    chk("R10 emptied", {35'd0, b_mbx_full_no}, 36'd1);
  endtask

  task automatic t_concurrent();
    fork
      a_mbx_load(36'h7_0000_0007);
      b_mbx_load(36'h8_0000_0008);
    join
    wait_b(6);
    chk("R11 b flag", {35'd0, b_mbx_full_no}, 36'd0);
    chk("R11 a flag", {35'd0, a_mbx_full_no}, 36'd0);
    a_set(1'b0, 1'b0, 1'b0, 1'b1);
    b_set(1'b0, 1'b1, 1'b0, 1'b1);
    #1;
    chk("R11 a sees b word", a_data_o, 36'h8_0000_0008);
    chk("R11 b sees a word", b_data_o, 36'h7_0000_0007);
    a_set(1'b1, 1'b1, 1'b0, 1'b0); b_set(1'b1, 1'b0, 1'b0, 1'b0);
    b_mbx_take();
    chk("R11 b emptied, a untouched", {34'd0, b_mbx_full_no, a_mbx_full_no}, 36'd2);
    @(negedge clk_a); a_set(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk_a); a_set(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 a emptied", {35'd0, a_mbx_full_no}, 36'd1);
  endtask

  task automatic t_collision();
    bit seen_low = 1'b0;
    @(negedge clk_b); b_set(1'b0, 1'b1, 1'b1, 1'b1);
    a_mbx_load(36'h5_5555_AAAA);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_b);
      if (!b_mbx_full_no) seen_low = 1'b1;
    end
    chk("R12 set wins", {35'd0, seen_low}, 36'd1);
    chk("R12 cleared later", {35'd0, b_mbx_full_no}, 36'd1);
    chk("R12 word", b_data_o, 36'h5_5555_AAAA);
    b_set(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a_set(1'b1, 1'b1, 1'b0, 1'b0); b_set(1'b1, 1'b0, 1'b0, 1'b0);
    a_data_i = '0; b_data_i = '0;
    a_in_rdy_i = 1'b0; a_out_rdy_i = 1'b0; b_in_rdy_i = 1'b0; b_out_rdy_i = 1'b0;
    #20 rst_ni = 1'b1;
    wait_b(2);
    t_reset();
    t_oe();
    t_fifo_strobes();
    t_mbx_ab();
    t_en_low();
    t_overwrite();
    t_concurrent();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule